// File: doc/BRIEF.md
# Compute Mode Entry Handshake Controller

This block lets software move a processor subsystem into and out of a compute-only operating mode through a single control word. Software sets a request bit to ask for entry and clears it to ask for exit. The block raises a mode request toward the platform and waits for the platform to pulse a ready input, which marks the end of each transition.

A read-only acknowledge bit reports progress. It is asymmetric: it rises only when entry has completed, and it falls only when exit has completed. An optional wake-on-interrupt enable lets hardware withdraw the request on any interrupt or exception vector fetch. When the fetch and a software write fall in the same cycle, the hardware clear wins. If the request is withdrawn before entry completes, the block goes straight to exit and the acknowledge never rises.

Top module: `compute_mode_hs`

## Requirements
- R1: After reset the control word reads 0 and `mode_req` is 0.
- R2: A write with bit 0 set makes bit 0 read 1 from the next cycle; one cycle after that, `mode_req` is 1. A write with bit 0 clear makes bit 0 read 0 from the next cycle.
- R3: Once entry has started, the acknowledge (bit 1) stays 0 until a cycle in which `plat_rdy` is high. It reads 1 from the cycle after that one.
- R4: After the request is withdrawn from the active mode, `mode_req` drops one cycle later. The acknowledge stays 1 until a `plat_rdy` pulse arrives, and reads 0 from the cycle after that pulse.
- R5: If the request is withdrawn while entry is still in progress, `mode_req` drops and the acknowledge never reads 1. The exit still needs one `plat_rdy` pulse before a new entry can begin.
- R6: When the wake-on-interrupt enable (bit 2) reads 1, a cycle with `vec_fetch` high clears bit 0 from the next cycle.
- R7: When the wake-on-interrupt enable reads 0, `vec_fetch` leaves bit 0 unchanged.
- R8: A hardware clear from `vec_fetch` overrides a software write of 1 to bit 0 in the same cycle.
- R9: Writes to bit 1 and to bits 31:3 have no effect. Bits 31:3 always read 0.
- R10: A `plat_rdy` pulse has no effect when no transition is in progress, in either the idle mode or the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback: bit 0 request, bit 1 acknowledge, bit 2 wake enable |
| vec_fetch | input | 1 | Interrupt or exception vector fetch in progress |
| mode_req | output | 1 | Request toward the platform to be in compute mode |
| plat_rdy | input | 1 | Platform pulse: the current transition has finished |

## Verification
Directed sequences cover a full entry and exit with ready pulses delayed by several cycles, a withdrawal during entry, and ready pulses sent while idle or active. Together these separate the asymmetric acknowledge from a plain mirror of the request. Vector fetches are sent with the wake enable on and off, and once in the same cycle as a write of 1, which exposes a wrong enable gate or a wrong priority. Writes with every bit set show whether the acknowledge and reserved bits leak into state. A long seeded random run of writes, fetches and ready pulses is then compared each cycle against a reference model in the bench, to catch interleavings that the directed cases miss.

// File: rtl/compute_mode_hs.sv
module compute_mode_hs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          vec_fetch,
  output logic          mode_req,
  input  logic          plat_rdy
);
  localparam int REQ_B = 0;
  localparam int ACK_B = 1;
  localparam int WOI_B = 2;
  localparam int PAD_W = DW - 3;

  typedef enum logic [1:0] {S_IDLE, S_ENTER, S_ACTIVE, S_EXIT} st_t;

  st_t  st_q;
  logic req_q, woi_q, ack_q;
  logic hw_clr;

  assign hw_clr = woi_q & vec_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      woi_q <= 1'b0;
    end else begin
      if (wr_en) woi_q <= wr_data[WOI_B];
      if (hw_clr)     req_q <= 1'b0;
      else if (wr_en) req_q <= wr_data[REQ_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ack_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE:   if (req_q) st_q <= S_ENTER;
        S_ENTER:
          if (!req_q) st_q <= S_EXIT;
          else if (plat_rdy) begin
            st_q  <= S_ACTIVE;
            ack_q <= 1'b1;
          end
        S_ACTIVE: if (!req_q) st_q <= S_EXIT;
        S_EXIT:
          if (plat_rdy) begin
            st_q  <= S_IDLE;
            ack_q <= 1'b0;
          end
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  assign mode_req = (st_q == S_ENTER) || (st_q == S_ACTIVE);
  assign rd_data  = {{PAD_W{1'b0}}, woi_q, ack_q, req_q};

  logic unused_ok;
  assign unused_ok = ^{wr_data[DW-1:WOI_B+1], wr_data[ACK_B]};
endmodule

// File: rtl/compute_mode_hs_chk.sv
module compute_mode_hs_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          vec_fetch,
  input logic          mode_req,
  input logic          plat_rdy
);
  // R3
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> $past(plat_rdy) && $past(mode_req));

  // R4
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[1]) |-> $past(plat_rdy) && !$past(mode_req));

  // R6
  woi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch && rd_data[2] |=> !rd_data[0]);

  // R7
  no_woi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch && !rd_data[2] && !wr_en |=> $stable(rd_data[0]));

  // R9
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:3] == '0);

  // R5
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> $past(rd_data[0]));

  logic unused_ok;
  assign unused_ok = ^wr_data;
endmodule

bind compute_mode_hs compute_mode_hs_chk #(.DW(DW)) u_chk (.*);

// File: tb/compute_mode_hs_tb.sv
`timescale 1ns/1ps
module compute_mode_hs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        vec_fetch = 1'b0;
  logic        mode_req;
  logic        plat_rdy = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  compute_mode_hs u_dut (.*);

  // reference model, computed from the requirements
  logic [1:0] m_st;
  logic m_req, m_woi, m_ack;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 2'd0; m_req <= 1'b0; m_woi <= 1'b0; m_ack <= 1'b0;
    end else begin
      if (wr_en) m_woi <= wr_data[2];
      m_req <= (m_woi && vec_fetch) ? 1'b0 : (wr_en ? wr_data[0] : m_req);
      case (m_st)
        2'd0: if (m_req) m_st <= 2'd1;
        2'd1: if (!m_req) m_st <= 2'd3;
              else if (plat_rdy) begin m_st <= 2'd2; m_ack <= 1'b1; end
        2'd2: if (!m_req) m_st <= 2'd3;
        default: if (plat_rdy) begin m_st <= 2'd0; m_ack <= 1'b0; end
      endcase
    end
  end

  function automatic logic [31:0] exp_word();
    return {29'd0, m_woi, m_ack, m_req};
  endfunction

  function automatic logic exp_mreq();
    return (m_st == 2'd1) || (m_st == 2'd2);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 1'b0; vec_fetch = 1'b0; plat_rdy = 1'b0;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d; tick();
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 word", rd_data, 32'h0);
    chk("R1 mreq", {31'd0, mode_req}, 32'h0);
    rst_n = 1'b1;
    tick();

    // full entry and exit
    wr(32'h1);
    chk("R2 req bit", rd_data, 32'h1);
    chk("R2 mreq not yet", {31'd0, mode_req}, 32'h0);
    tick();
    chk("R2 mreq", {31'd0, mode_req}, 32'h1);
    repeat (4) tick();
    chk("R3 ack waits", rd_data, 32'h1);
    plat_rdy = 1'b1; tick();
    chk("R3 ack set", rd_data, 32'h3);
    plat_rdy = 1'b1; tick();
    chk("R10 rdy active", {rd_data[30:0], mode_req}, {32'h3, 1'b1} >> 0);
    wr(32'h0);
    chk("R4 ack held", rd_data, 32'h2);
    tick();
    chk("R4 mreq drop", {31'd0, mode_req}, 32'h0);
    repeat (3) tick();
    chk("R4 ack still", rd_data, 32'h2);
    plat_rdy = 1'b1; tick();
    chk("R4 ack clear", rd_data, 32'h0);
    plat_rdy = 1'b1; tick();
    chk("R10 rdy idle", {rd_data[30:0], mode_req}, 32'h0);

    // withdrawal during entry
    wr(32'h1); tick();
    chk("R5 entering", {31'd0, mode_req}, 32'h1);
    wr(32'h0); tick();
    chk("R5 mreq drop", {rd_data[30:0], mode_req}, 32'h0);
    wr(32'h1); tick();
    chk("R5 exit pending", {31'd0, mode_req}, 32'h0);
    plat_rdy = 1'b1; tick();
    chk("R5 ack never", rd_data, 32'h1);
    tick();
    chk("R5 reenter", {31'd0, mode_req}, 32'h1);

    // wake on interrupt
    wr(32'h5);
    vec_fetch = 1'b1; tick();
    chk("R6 hw clear", rd_data, 32'h4);
    wr(32'h1);
    vec_fetch = 1'b1; tick();
    chk("R7 no clear", rd_data, 32'h1);
    wr(32'h4);
    wr_en = 1'b1; wr_data = 32'h5; vec_fetch = 1'b1; tick();
    chk("R8 priority", rd_data, 32'h4);
    wr(32'hFFFF_FFFA);
    chk("R9 ignored", rd_data, 32'h0);
    wr(32'hFFFF_FFFF);
    chk("R9 pad zero", rd_data[31:3], 32'h0);

    // seeded random against model
    void'($urandom(32'h5eed));
    for (int i = 0; i < 3000; i++) begin
      wr_en     = ($urandom % 6) == 0;
      wr_data   = $urandom;
      vec_fetch = ($urandom % 8) == 0;
      plat_rdy  = ($urandom % 4) == 0;
      @(posedge clk); #1;
      chk("R10 random word", rd_data, exp_word());
      chk("R3 random mreq", {31'd0, mode_req}, {31'd0, exp_mreq()});
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule